// File: doc/BRIEF.md
# Serial Bit-Clock Generator

This block produces the timing enables for one serial channel that works either as an asynchronous UART or as a clock-synchronous shift port. It sits in the system clock domain and generates no derived clock. Every output is a single-cycle enable or a registered pin level, so the transmit and receive logic downstream runs on the system clock and qualifies its updates with these pulses.

The timing source comes from the system clock. A half-rate option sets the base rate. From the base rate, a two-stage prescaler derives a divided-by-8 rate and a divided-by-32 rate. A source select picks one of these three rates. A reload counter then divides the selected rate by an 8-bit divisor plus one. A mode-dependent last stage finishes the chain. In UART modes it counts sixteen divided pulses per bit tick to give the oversampling rate. In synchronous mode it toggles a shift clock, which is driven out on the clock pin.

In synchronous mode the channel can instead be clocked from outside. The external clock pin passes through a synchronizer, and its edges become the shift and sample enables. A polarity control selects which clock edge shifts data out and which edge samples data in.

Top module: `sclk_gen`

## Requirements
- R1: With `half_sel`=0 the base rate is one pulse per system clock cycle. With `half_sel`=1 it is one pulse every 2 cycles.
- R2: `src_sel` picks the source period P. Code 00 gives the base rate. Code 01 gives base/8. Code 10 gives base/32. Code 11 gives no source pulses, so no ticks and no internal shift clock edges occur.
- R3: The selected source is divided by `divisor`+1, giving one divided pulse every (`divisor`+1)·P cycles.
- R4: In the UART modes (`mode` 100, 101 or 110), `uart_tick` pulses for one cycle every 16·(`divisor`+1)·P cycles.
- R5: In synchronous mode (`mode` 001) with `ext_sel`=0, `sck_oe` is 1. In that mode `sck_out` toggles every (`divisor`+1)·P cycles, and it changes level only in a cycle where `tx_shift` or `rx_sample` is high.
- R6: With `clk_pol`=0, `tx_shift` accompanies a falling `sck_out` (it reads 0 in that cycle) and `rx_sample` accompanies a rising one. With `clk_pol`=1 the two roles swap. `tx_shift` therefore pulses every 2·(`divisor`+1)·P cycles.
- R7: In synchronous mode with `ext_sel`=1, `sck_oe` is 0. Each edge on `sck_in` yields exactly one pulse within 6 cycles: `tx_shift` for a falling edge and `rx_sample` for a rising one when `clk_pol`=0, and the reverse when `clk_pol`=1. In UART modes, `sck_in` and `ext_sel` have no effect.
- R8: Mode codes 000, 010, 011 and 111 disable the block. From the next cycle on, there are no enables, `sck_out` is 1 and `sck_oe` is 0.
- R9: A new `divisor` value takes effect only at the next reload. The period already in progress completes with the old value.
- R10: At most one of `uart_tick`, `tx_shift` and `rx_sample` is high in any cycle, and `uart_tick` is never high in two consecutive cycles.
- R11: While `rst_n` is low, and right after reset with `mode` 000, `uart_tick`=0, `sck_oe`=0 and `sck_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Channel mode: 001 synchronous, 100/101/110 UART, others disabled |
| src_sel | input | 2 | Source select: 00 base, 01 base/8, 10 base/32, 11 none |
| half_sel | input | 1 | Base rate select: 0 full rate, 1 half rate |
| ext_sel | input | 1 | Synchronous clock origin: 0 internal, 1 external pin |
| clk_pol | input | 1 | Shift/sample edge polarity in synchronous mode |
| divisor | input | DIV_W | Reload value n; divide by n+1 |
| sck_in | input | 1 | External shift clock pin, asynchronous |
| sck_out | output | 1 | Internal shift clock level for the pin, idle high |
| sck_oe | output | 1 | Drive enable for the clock pin |
| uart_tick | output | 1 | UART oversampling enable |
| tx_shift | output | 1 | Synchronous transmit shift enable |
| rx_sample | output | 1 | Synchronous receive sample enable |

## Verification
The hardest case to reach from the ports is a divisor write that lands partway through a divide period. An unsynchronized write gives no clear sign of whether the old period was honoured. The bench therefore locks onto an observed toggle of the internal shift clock and writes the new divisor in that same sampling slot. It then requires one more gap at the old length, followed by gaps at the new length. Edges from the external clock are timed through the synchronizer by moving `sck_in` alone and counting the enables that follow in a short window. Random configurations draw from every source, rate and mode, with periods kept short enough for several gaps per draw.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   localparam logic [2:0] MODE_SYNC  = 3'b001;
   localparam logic [2:0] MODE_UA7   = 3'b100;
   localparam logic [2:0] MODE_UA8   = 3'b101;
   localparam logic [2:0] MODE_UA9   = 3'b110;

   localparam logic [1:0] SRC_BASE   = 2'b00;
   localparam logic [1:0] SRC_DIV_A  = 2'b01;
   localparam logic [1:0] SRC_DIV_AB = 2'b10;

   function automatic logic mode_is_uart(input logic [2:0] m);
      return (m == MODE_UA7) || (m == MODE_UA8) || (m == MODE_UA9);
   endfunction

   function automatic logic mode_is_sync(input logic [2:0] m);
      return m == MODE_SYNC;
   endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale
   import sclk_pkg::*;
#(
   parameter int RATIO_A = 8,
   parameter int RATIO_B = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       half_sel,
   input  logic [1:0] src_sel,
   output logic       src_en
);
   localparam int AW = (RATIO_A > 1) ? $clog2(RATIO_A) : 1;
   localparam int BW = (RATIO_B > 1) ? $clog2(RATIO_B) : 1;
   localparam logic [AW-1:0] A_LAST = AW'(RATIO_A - 1);
   localparam logic [BW-1:0] B_LAST = BW'(RATIO_B - 1);

   logic          half_ph;
   logic          base_en;
   logic [AW-1:0] cnt_a;
   logic [BW-1:0] cnt_b;
   logic          a_en;
   logic          b_en;

   assign base_en = half_sel ? half_ph : 1'b1;
   assign a_en    = base_en && (cnt_a == A_LAST);
   assign b_en    = a_en && (cnt_b == B_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         half_ph <= 1'b0;
      end else begin
         half_ph <= ~half_ph;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_a <= '0;
      end else if (base_en) begin
         cnt_a <= (cnt_a == A_LAST) ? '0 : cnt_a + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_b <= '0;
      end else if (a_en) begin
         cnt_b <= (cnt_b == B_LAST) ? '0 : cnt_b + 1'b1;
      end
   end

   always_comb begin
      unique case (src_sel)
         SRC_BASE:   src_en = base_en;
         SRC_DIV_A:  src_en = a_en;
         SRC_DIV_AB: src_en = b_en;
         default:    src_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/sclk_reload.sv
module sclk_reload #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_en,
   input  logic [DIV_W-1:0] divisor,
   output logic             div_pulse
);
   logic [DIV_W-1:0] remain;

   assign div_pulse = src_en && (remain == '0);

   // The divisor is sampled only when the count reloads.
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         remain <= '0;
      end else if (src_en) begin
         remain <= (remain == '0) ? divisor : remain - 1'b1;
      end
   end

endmodule

// File: rtl/sclk_final.sv
module sclk_final #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uart_run,
   input  logic sync_run,
   input  logic div_pulse,
   output logic uart_pulse,
   output logic sck_lvl,
   output logic sck_rise,
   output logic sck_fall
);
   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [CW-1:0] O_LAST = CW'(OVS - 1);
   localparam bit OVS_POW2 = (OVS & (OVS - 1)) == 0;

   logic [CW-1:0] ovs_cnt;
   logic          ovs_wrap;

   assign ovs_wrap   = ovs_cnt == O_LAST;
   assign uart_pulse = uart_run && div_pulse && ovs_wrap;

   generate
      if (OVS_POW2) begin : g_ovs_pow2
         always_ff @(posedge clk) begin
            if (!rst_n || !uart_run) begin
               ovs_cnt <= '0;
            end else if (div_pulse) begin
               ovs_cnt <= ovs_cnt + 1'b1;
            end
         end
      end else begin : g_ovs_mod
         always_ff @(posedge clk) begin
            if (!rst_n || !uart_run) begin
               ovs_cnt <= '0;
            end else if (div_pulse) begin
               ovs_cnt <= ovs_wrap ? '0 : ovs_cnt + 1'b1;
            end
         end
      end
   endgenerate

   assign sck_rise = sync_run && div_pulse && !sck_lvl;
   assign sck_fall = sync_run && div_pulse && sck_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n || !sync_run) begin
         sck_lvl <= 1'b1;
      end else if (div_pulse) begin
         sck_lvl <= ~sck_lvl;
      end
   end

endmodule

// File: rtl/sclk_extclk.sv
module sclk_extclk #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= pin;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pin};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] && !prev;
   assign fall = !chain[STAGES-1] && prev;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
   import sclk_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 8,
   parameter int PRE_B       = 4,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   input  logic [1:0]       src_sel,
   input  logic             half_sel,
   input  logic             ext_sel,
   input  logic             clk_pol,
   input  logic [DIV_W-1:0] divisor,
   input  logic             sck_in,
   output logic             sck_out,
   output logic             sck_oe,
   output logic             uart_tick,
   output logic             tx_shift,
   output logic             rx_sample
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("sclk_gen: DIV_W must be at least 1");
      end
      if (PRE_A < 2 || PRE_B < 2) begin : g_bad_pre
         $error("sclk_gen: prescaler ratios must be at least 2");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("sclk_gen: OVS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sclk_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic uart_on, sync_on, int_sync, run;
   logic src_en, div_pulse, uart_pulse;
   logic sck_lvl, int_rise, int_fall;
   logic ext_rise, ext_fall;
   logic ev_rise, ev_fall, tx_d, rx_d;

   assign uart_on  = mode_is_uart(mode);
   assign sync_on  = mode_is_sync(mode);
   assign int_sync = sync_on && !ext_sel;
   assign run      = uart_on || int_sync;

   sclk_prescale #(.RATIO_A(PRE_A), .RATIO_B(PRE_B)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half_sel (half_sel),
      .src_sel  (src_sel),
      .src_en   (src_en)
   );

   sclk_reload #(.DIV_W(DIV_W)) u_rld (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .src_en    (src_en),
      .divisor   (divisor),
      .div_pulse (div_pulse)
   );

   sclk_final #(.OVS(OVS)) u_fin (
      .clk        (clk),
      .rst_n      (rst_n),
      .uart_run   (uart_on),
      .sync_run   (int_sync),
      .div_pulse  (div_pulse),
      .uart_pulse (uart_pulse),
      .sck_lvl    (sck_lvl),
      .sck_rise   (int_rise),
      .sck_fall   (int_fall)
   );

   sclk_extclk #(.STAGES(SYNC_STAGES)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sck_in),
      .rise  (ext_rise),
      .fall  (ext_fall)
   );

   assign ev_rise = int_sync ? int_rise : (sync_on && ext_rise);
   assign ev_fall = int_sync ? int_fall : (sync_on && ext_fall);
   assign tx_d    = clk_pol ? ev_rise : ev_fall;
   assign rx_d    = clk_pol ? ev_fall : ev_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uart_tick <= 1'b0;
         tx_shift  <= 1'b0;
         rx_sample <= 1'b0;
         sck_oe    <= 1'b0;
      end else begin
         uart_tick <= uart_pulse;
         tx_shift  <= tx_d;
         rx_sample <= rx_d;
         sck_oe    <= int_sync;
      end
   end

   assign sck_out = sck_lvl;

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode,
   input logic       ext_sel,
   input logic       clk_pol,
   input logic       sck_out,
   input logic       sck_oe,
   input logic       uart_tick,
   input logic       tx_shift,
   input logic       rx_sample
);
   logic mode_off;
   assign mode_off = !(mode == 3'b001 || mode == 3'b100 ||
                       mode == 3'b101 || mode == 3'b110);

   p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_off |=> (!uart_tick && !tx_shift && !rx_sample && !sck_oe && sck_out))
      else $error("R8: enables active after disabled mode");

   p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({uart_tick, tx_shift, rx_sample}))
      else $error("R10: more than one enable in a cycle");

   p_tick_spaced_r10: assert property (@(posedge clk) disable iff (!rst_n)
      uart_tick |=> !uart_tick)
      else $error("R10: back-to-back uart ticks");

   p_tx_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_shift && sck_oe) |-> (sck_out == $past(clk_pol)))
      else $error("R6: transmit enable on wrong clock edge");

   p_rx_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sample && sck_oe) |-> (sck_out != $past(clk_pol)))
      else $error("R6: receive enable on wrong clock edge");

   p_oe_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> ($past(mode) == 3'b001 && !$past(ext_sel)))
      else $error("R5: pin driven outside internal synchronous mode");

   p_sck_moves_with_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && !$stable(sck_out)) |-> (tx_shift || rx_sample))
      else $error("R5: shift clock moved without an enable");

endmodule

bind sclk_gen sclk_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .ext_sel   (ext_sel),
   .clk_pol   (clk_pol),
   .sck_out   (sck_out),
   .sck_oe    (sck_oe),
   .uart_tick (uart_tick),
   .tx_shift  (tx_shift),
   .rx_sample (rx_sample)
);

// File: tb/sclk_gen_test.sv
module sclk_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [1:0] src_sel = 2'b00;
   logic       half_sel = 1'b0;
   logic       ext_sel = 1'b0;
   logic       clk_pol = 1'b0;
   logic [7:0] divisor = 8'd0;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, uart_tick, tx_shift, rx_sample;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sclk_gen uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .src_sel(src_sel),
      .half_sel(half_sel), .ext_sel(ext_sel), .clk_pol(clk_pol),
      .divisor(divisor), .sck_in(sck_in), .sck_out(sck_out),
      .sck_oe(sck_oe), .uart_tick(uart_tick), .tx_shift(tx_shift),
      .rx_sample(rx_sample)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int src_period(input logic [1:0] s, input logic h);
      int b = h ? 2 : 1;
      case (s)
         2'b00:   return b;
         2'b01:   return 8 * b;
         2'b10:   return 32 * b;
         default: return 0;
      endcase
   endfunction

   function automatic bit hit(input int kind, input logic prev);
      case (kind)
         0:       return uart_tick;
         1:       return sck_out != prev;
         default: return tx_shift;
      endcase
   endfunction

   // Passes through the disabled state so every counter starts clean.
   task automatic configure(input logic [2:0] m, input logic [1:0] s,
                            input logic h, input logic e, input logic p,
                            input logic [7:0] d);
      @(negedge clk);
      mode = 3'b000;
      repeat (2) @(negedge clk);
      src_sel = s; half_sel = h; ext_sel = e; clk_pol = p; divisor = d;
      mode = m;
   endtask

   // kind 0: uart_tick, 1: sck_out toggle, 2: tx_shift. Returns -1 on timeout.
   task automatic gap(input int kind, input int limit, input bit armed,
                      output int cyc);
      logic prev = sck_out;
      bit   started = armed;
      bit   fin = 0;
      int   count = 0;
      cyc = -1;
      for (int n = 0; n < limit && !fin; n++) begin
         @(negedge clk);
         if (hit(kind, prev)) begin
            if (started) begin
               cyc = count + 1;
               fin = 1;
            end
            started = 1;
            count = 0;
         end else if (started) begin
            count++;
         end
         prev = sck_out;
      end
   endtask

   task automatic phase_watch(input int cycles, input logic p, input string req);
      int seen = 0;
      for (int n = 0; n < cycles && seen < 4; n++) begin
         @(negedge clk);
         if (tx_shift) begin
            check(sck_out == p, req, "sck_out at tx_shift", sck_out, p);
            seen++;
         end
         if (rx_sample) begin
            check(sck_out != p, req, "sck_out at rx_sample", sck_out, !p);
            seen++;
         end
      end
   endtask

   task automatic ext_edge(input logic v, output int ntx, output int nrx);
      @(negedge clk);
      sck_in = v;
      ntx = 0; nrx = 0;
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         if (tx_shift)  ntx++;
         if (rx_sample) nrx++;
      end
   endtask

   task automatic uart_case(input logic [2:0] m, input logic [1:0] s, input logic h,
                            input logic [7:0] d, input string req);
      int exp = 16 * (d + 1) * src_period(s, h);
      int g;
      configure(m, s, h, 1'b0, 1'b0, d);
      gap(0, 2 * exp + 64, 1'b0, g);
      check(g == exp, req, "uart_tick gap", g, exp);
      gap(0, exp + 64, 1'b1, g);
      check(g == exp, req, "uart_tick second gap", g, exp);
   endtask

   task automatic sync_case(input logic [1:0] s, input logic h, input logic p,
                            input logic [7:0] d, input string req);
      int half = (d + 1) * src_period(s, h);
      int g;
      configure(3'b001, s, h, 1'b0, p, d);
      gap(1, 2 * half + 64, 1'b0, g);
      check(g == half, {req, " R5"}, "sck_out toggle gap", g, half);
      check(sck_oe == 1'b1, "R5", "sck_oe in internal sync", sck_oe, 1);
      gap(2, 4 * half + 64, 1'b0, g);
      check(g == 2 * half, {req, " R6"}, "tx_shift gap", g, 2 * half);
      phase_watch(8 * half + 16, p, "R6");
   endtask

   initial begin
      int g, ntx, nrx, cnt;
      void'($urandom(32'd7321));

      // R11 reset state
      repeat (3) @(negedge clk);
      check(uart_tick == 1'b0, "R11", "uart_tick in reset", uart_tick, 0);
      check(sck_oe == 1'b0,    "R11", "sck_oe in reset", sck_oe, 0);
      check(sck_out == 1'b1,   "R11", "sck_out in reset", sck_out, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({uart_tick, tx_shift, rx_sample, sck_oe} == 4'b0, "R11",
            "enables after reset", {uart_tick, tx_shift, rx_sample, sck_oe}, 0);

      // R1 full versus half base rate
      uart_case(3'b101, 2'b00, 1'b0, 8'd1, "R1");
      uart_case(3'b101, 2'b00, 1'b1, 8'd1, "R1");
      // R2 prescaled sources
      uart_case(3'b100, 2'b01, 1'b0, 8'd0, "R2");
      uart_case(3'b110, 2'b10, 1'b0, 8'd0, "R2");
      // R3 R4 minimum divisor, and maximum divisor on the shift clock
      uart_case(3'b100, 2'b00, 1'b0, 8'd0, "R4");
      sync_case(2'b00, 1'b0, 1'b0, 8'd0, "R3");
      sync_case(2'b00, 1'b0, 1'b1, 8'd255, "R3");

      // R2 unused source code produces nothing
      configure(3'b101, 2'b11, 1'b0, 1'b0, 1'b0, 8'd0);
      cnt = 0;
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         if (uart_tick) cnt++;
      end
      check(cnt == 0, "R2", "ticks with source code 11", cnt, 0);

      // R8 disabled codes
      foreach (g_off_codes[k]) begin
         configure(g_off_codes[k], 2'b00, 1'b0, 1'b0, 1'b0, 8'd0);
         cnt = 0;
         for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (uart_tick || tx_shift || rx_sample || sck_oe || !sck_out) cnt++;
         end
         check(cnt == 0, "R8", $sformatf("activity with mode %b", g_off_codes[k]), cnt, 0);
      end

      // R9 divisor written right after a toggle
      configure(3'b001, 2'b00, 1'b0, 1'b0, 1'b0, 8'd9);
      gap(1, 100, 1'b0, g);
      divisor = 8'd3;
      gap(1, 100, 1'b1, g);
      check(g == 10, "R9", "gap after write keeps old divisor", g, 10);
      gap(1, 100, 1'b1, g);
      check(g == 4, "R9", "gap with new divisor", g, 4);

      // R7 external clock, both polarities
      configure(3'b001, 2'b00, 1'b0, 1'b1, 1'b0, 8'd0);
      repeat (4) @(negedge clk);
      check(sck_oe == 1'b0, "R7", "sck_oe with external clock", sck_oe, 0);
      ext_edge(1'b0, ntx, nrx);
      check(ntx == 1 && nrx == 0, "R7", "pol0 falling edge tx count", ntx, 1);
      ext_edge(1'b1, ntx, nrx);
      check(nrx == 1 && ntx == 0, "R7", "pol0 rising edge rx count", nrx, 1);
      clk_pol = 1'b1;
      ext_edge(1'b0, ntx, nrx);
      check(nrx == 1 && ntx == 0, "R7", "pol1 falling edge rx count", nrx, 1);
      ext_edge(1'b1, ntx, nrx);
      check(ntx == 1 && nrx == 0, "R7", "pol1 rising edge tx count", ntx, 1);

      // R7 external pin ignored in UART mode
      configure(3'b101, 2'b00, 1'b0, 1'b1, 1'b0, 8'd2);
      ext_edge(1'b0, ntx, nrx);
      check(ntx + nrx == 0, "R7", "sync enables from pin in UART", ntx + nrx, 0);
      ext_edge(1'b1, ntx, nrx);
      gap(0, 200, 1'b0, g);
      check(g == 48, "R7", "uart gap with ext_sel set", g, 48);

      // Random configurations
      for (int i = 0; i < 12; i++) begin
         logic [1:0] s = 2'($urandom % 3);
         logic       h = 1'($urandom % 2);
         logic       p = 1'($urandom % 2);
         logic [7:0] d;
         if ($urandom % 2) begin
            logic [2:0] m = 3'b100 + 3'($urandom % 3);
            d = 8'($urandom % 4);
            if (s == 2'b10) h = 1'b0;
            uart_case(m, s, h, d, "R4");
         end else begin
            d = (s == 2'b00) ? 8'($urandom % 256) : 8'($urandom % 16);
            sync_case(s, h, p, d, "R3");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [2:0] g_off_codes [4] = '{3'b000, 3'b010, 3'b011, 3'b111};

   // R10 exclusivity observed at the ports throughout the run
   always @(negedge clk) begin
      if (rst_n && (int'(uart_tick) + int'(tx_shift) + int'(rx_sample)) > 1) begin
         check(1'b0, "R10", "simultaneous enables", 2, 1);
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", "run did not finish", WATCHDOG, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule